// File: doc/BRIEF.md
# Vectored Core-Local Interrupt Controller

This block sits beside a processor core and collects a configurable number of interrupt request lines, 86 by default. Every source has four byte-wide registers: a pending flag, an enable flag, an attribute byte and an 8-bit control (level/priority) value. Software reaches them over a simple byte-addressed register bus. Each input first crosses a two-flop synchronizer. It is then taken as a level, a rising edge or a falling edge, according to that source's attribute.

Among the sources that are both pending and enabled, the controller chooses one. It presents that source to the core, gated by the global machine interrupt enable. The request comes with its ID, a flag that says whether the source uses vectored dispatch, the matching cause word and the address the core fetches the handler from. A vectored source gets a per-source slot in a power-of-two-aligned table. A non-vectored source goes to a common, 64-byte-aligned trap entry. When the core takes an interrupt, it pulses an acknowledge with the ID, and this clears the pending flag of an edge-triggered source.

Top module: `vclic`

## Requirements
- R1: After reset every source register reads zero and `irq_req_o` is low.
- R2: Register byte address is source*4 + field. Field 0 is pending (bit 0), 1 is enable (bit 0), 2 is attribute (bits [2:0]) and 3 is control (bits [7:0]). Unimplemented bits read zero. Addresses of sources at or above the source count read zero and ignore writes.
- R3: A source requests only when its pending bit and its enable bit are both 1. `irq_req_o` is asserted only while `mie_i` is 1.
- R4: A source with attribute bits [2:1] = 00 or 01 is level-triggered. Its pending bit follows the input, and a change of the input shows on the outputs after the third rising clock edge following it.
- R5: With attribute bits [2:1] = 10, a 0-to-1 input transition sets pending, and pending stays set after the input returns low.
- R6: With attribute bits [2:1] = 11, a 1-to-0 input transition sets pending, and a 0-to-1 transition does not.
- R7: An `ack_i` pulse with `ack_id_i` equal to the source ID clears the pending bit of an edge-triggered source. It has no effect on a level-triggered source.
- R8: A write to the pending byte sets or clears pending (data bit 0) for an edge-triggered source. For a level-triggered source the write is ignored.
- R9: The winner is the requesting source with the largest control value. On equal control values, the higher ID wins.
- R10: `cause_o` has bit 31 set, bits [30:12] zero and the winning ID in bits [11:0].
- R11: When the winner's attribute bit 0 is 1, `irq_vec_o` is 1 and `handler_addr_o` is `tbl_base_i` with its low A bits replaced by ID*4. A is log2 of the smallest power of two that is at least 64 and at least 4*NUM_SRC (9 for 86 sources).
- R12: When the winner's attribute bit 0 is 0, `irq_vec_o` is 0 and `handler_addr_o` is `trap_entry_i` with bits [5:0] cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | NUM_SRC | Raw interrupt request lines |
| mie_i | input | 1 | Global machine interrupt enable |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | clog2(NUM_SRC*4) | Register byte address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| ack_i | input | 1 | Core takes an interrupt |
| ack_id_i | input | 12 | ID being acknowledged |
| tbl_base_i | input | 32 | Vector table base |
| trap_entry_i | input | 32 | Common trap entry address |
| irq_req_o | output | 1 | Interrupt request to the core |
| irq_id_o | output | 12 | Winning source ID |
| irq_vec_o | output | 1 | Winner uses vectored dispatch |
| cause_o | output | 32 | Cause word for the winner |
| handler_addr_o | output | 32 | Handler fetch address |

## Verification
Some properties are checked on every cycle: the global-enable gate, a one-hot grant that only lands on a source that is requesting, the layout of the cause word, and the alignment of both handler-address forms. The arbitration order under ties, the three trigger kinds with their synchronizer latency, acknowledge clearing and ignored software writes to level sources all depend on sequences of stimulus. Only the bench's directed and randomized scenarios can show those, comparing the outputs against its own model of the register state.

// File: rtl/vclic_pkg.sv
package vclic_pkg;

  localparam int unsigned ID_W  = 12;
  localparam int unsigned CTL_W = 8;

  typedef enum logic [1:0] {
    FLD_PEND = 2'd0,
    FLD_EN   = 2'd1,
    FLD_ATTR = 2'd2,
    FLD_CTL  = 2'd3
  } reg_fld_e;

  // Table alignment exponent: at least 64 bytes, covering 4 bytes per source.
  function automatic int unsigned table_align_log2(input int unsigned nsrc);
    int unsigned b;
    b = $clog2(nsrc * 4);
    return (b < 6) ? 6 : b;
  endfunction

  // Attribute bit 2 set means edge detection; bit 1 then picks the falling edge.
  function automatic logic attr_is_edge(input logic [2:0] attr);
    return attr[2];
  endfunction

  function automatic logic [31:0] make_cause(input logic [ID_W-1:0] id);
    return {1'b1, 19'd0, id};
  endfunction

  function automatic logic [31:0] vector_slot(input logic [31:0] base,
                                              input logic [ID_W-1:0] id,
                                              input int unsigned align_log2);
    logic [31:0] mask;
    mask = (32'd1 << align_log2) - 32'd1;
    return (base & ~mask) | ({20'd0, id} << 2);
  endfunction

  function automatic logic [31:0] common_entry(input logic [31:0] entry);
    return {entry[31:6], 6'd0};
  endfunction

endpackage

// File: rtl/vclic_sync_edge.sv
module vclic_sync_edge #(
  parameter int unsigned NUM_SRC = 86
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_i,
  output logic [NUM_SRC-1:0] lvl_o,
  output logic [NUM_SRC-1:0] rise_o,
  output logic [NUM_SRC-1:0] fall_o
);

  logic [NUM_SRC-1:0] meta_q;
  logic [NUM_SRC-1:0] sync_q;
  logic [NUM_SRC-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= irq_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign lvl_o  = sync_q;
  assign rise_o = sync_q & ~prev_q;
  assign fall_o = ~sync_q & prev_q;

endmodule

// File: rtl/vclic_arbiter.sv
module vclic_arbiter
  import vclic_pkg::*;
#(
  parameter int unsigned NUM_SRC = 86
) (
  input  logic [NUM_SRC-1:0]            req_i,
  input  logic [NUM_SRC-1:0][CTL_W-1:0] ctl_i,
  output logic [NUM_SRC-1:0]            grant_o,
  output logic                          any_o,
  output logic [ID_W-1:0]               id_o
);

  logic [CTL_W-1:0] best_c;
  logic             found_c;
  logic [ID_W-1:0]  win_c;

  // Ascending scan with >= so a later (higher) ID takes an equal control value.
  always_comb begin
    best_c  = '0;
    found_c = 1'b0;
    win_c   = '0;
    grant_o = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (req_i[i] && (!found_c || ctl_i[i] >= best_c)) begin
        found_c    = 1'b1;
        best_c     = ctl_i[i];
        win_c      = ID_W'(i);
        grant_o    = '0;
        grant_o[i] = 1'b1;
      end
    end
  end

  assign any_o = found_c;
  assign id_o  = win_c;

endmodule

// File: rtl/vclic_addr_gen.sv
module vclic_addr_gen
  import vclic_pkg::*;
#(
  parameter int unsigned ALIGN_LOG2 = 9
) (
  input  logic            vec_i,
  input  logic [ID_W-1:0] id_i,
  input  logic [31:0]     tbl_base_i,
  input  logic [31:0]     trap_entry_i,
  output logic [31:0]     handler_o,
  output logic [31:0]     cause_o
);

  assign handler_o = vec_i ? vector_slot(tbl_base_i, id_i, ALIGN_LOG2)
                           : common_entry(trap_entry_i);
  assign cause_o   = make_cause(id_i);

endmodule

// File: rtl/vclic.sv
module vclic
  import vclic_pkg::*;
#(
  parameter int unsigned NUM_SRC = 86,
  localparam int unsigned ADDR_W = $clog2(NUM_SRC * 4)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_i,
  input  logic               mie_i,
  input  logic               reg_wr_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [7:0]         reg_wdata_i,
  output logic [7:0]         reg_rdata_o,
  input  logic               ack_i,
  input  logic [ID_W-1:0]    ack_id_i,
  input  logic [31:0]        tbl_base_i,
  input  logic [31:0]        trap_entry_i,
  output logic               irq_req_o,
  output logic [ID_W-1:0]    irq_id_o,
  output logic               irq_vec_o,
  output logic [31:0]        cause_o,
  output logic [31:0]        handler_addr_o
);

  localparam int unsigned SIDX_W     = ADDR_W - 2;
  localparam int unsigned ALIGN_LOG2 = table_align_log2(NUM_SRC);

  // Named internal events, also used by the bound checker.
  logic [NUM_SRC-1:0]            lvl_w, rise_w, fall_w;
  logic [NUM_SRC-1:0]            pend_v, en_v, vec_v, req_v, grant_w;
  logic [NUM_SRC-1:0][2:0]       attr_v;
  logic [NUM_SRC-1:0][CTL_W-1:0] ctl_v;
  logic [NUM_SRC-1:0]            wr_sel;
  logic                          any_w, win_vec;
  logic [ID_W-1:0]               win_id;

  logic [SIDX_W-1:0] sidx;
  logic [1:0]        fld;
  logic              in_range;

  assign sidx     = reg_addr_i[ADDR_W-1:2];
  assign fld      = reg_addr_i[1:0];
  assign in_range = (32'(sidx) < NUM_SRC);

  always_comb begin
    wr_sel = '0;
    if (reg_wr_i && in_range) wr_sel[sidx] = 1'b1;
  end

  vclic_sync_edge #(.NUM_SRC(NUM_SRC)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .irq_i  (irq_i),
    .lvl_o  (lvl_w),
    .rise_o (rise_w),
    .fall_o (fall_w)
  );

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic             pend_r, en_r;
    logic [2:0]       attr_r;
    logic [CTL_W-1:0] ctl_r;
    logic             edge_mode, edge_hit, ack_hit;

    assign edge_mode = attr_is_edge(attr_r);
    assign edge_hit  = attr_r[1] ? fall_w[g] : rise_w[g];
    assign ack_hit   = ack_i && (ack_id_i == ID_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_r <= 1'b0;
        en_r   <= 1'b0;
        attr_r <= '0;
        ctl_r  <= '0;
      end else begin
        if (wr_sel[g] && fld == FLD_EN)   en_r   <= reg_wdata_i[0];
        if (wr_sel[g] && fld == FLD_ATTR) attr_r <= reg_wdata_i[2:0];
        if (wr_sel[g] && fld == FLD_CTL)  ctl_r  <= reg_wdata_i;
        // Software write outranks a new edge, which outranks an acknowledge.
        if (!edge_mode)                        pend_r <= lvl_w[g];
        else if (wr_sel[g] && fld == FLD_PEND) pend_r <= reg_wdata_i[0];
        else if (edge_hit)                     pend_r <= 1'b1;
        else if (ack_hit)                      pend_r <= 1'b0;
      end
    end

    assign pend_v[g] = pend_r;
    assign en_v[g]   = en_r;
    assign attr_v[g] = attr_r;
    assign ctl_v[g]  = ctl_r;
    assign vec_v[g]  = attr_r[0];
  end

  always_comb begin
    reg_rdata_o = '0;
    if (in_range) begin
      case (fld)
        FLD_PEND: reg_rdata_o = {7'd0, pend_v[sidx]};
        FLD_EN:   reg_rdata_o = {7'd0, en_v[sidx]};
        FLD_ATTR: reg_rdata_o = {5'd0, attr_v[sidx]};
        default:  reg_rdata_o = ctl_v[sidx];
      endcase
    end
  end

  assign req_v = pend_v & en_v;

  vclic_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
    .req_i   (req_v),
    .ctl_i   (ctl_v),
    .grant_o (grant_w),
    .any_o   (any_w),
    .id_o    (win_id)
  );

  assign win_vec = |(grant_w & vec_v);

  vclic_addr_gen #(.ALIGN_LOG2(ALIGN_LOG2)) u_addr (
    .vec_i        (win_vec),
    .id_i         (win_id),
    .tbl_base_i   (tbl_base_i),
    .trap_entry_i (trap_entry_i),
    .handler_o    (handler_addr_o),
    .cause_o      (cause_o)
  );

  assign irq_req_o = any_w && mie_i;
  assign irq_id_o  = win_id;
  assign irq_vec_o = win_vec;

endmodule

// File: rtl/vclic_checker.sv
module vclic_checker
  import vclic_pkg::*;
#(
  parameter int unsigned NUM_SRC = 86
) (
  input logic               clk,
  input logic               rst_n,
  input logic               mie_i,
  input logic               irq_req_o,
  input logic [ID_W-1:0]    irq_id_o,
  input logic               irq_vec_o,
  input logic [31:0]        cause_o,
  input logic [31:0]        handler_addr_o,
  input logic [NUM_SRC-1:0] grant_w,
  input logic [NUM_SRC-1:0] req_v
);

  localparam int unsigned AL = table_align_log2(NUM_SRC);

  p_req_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req_o |-> mie_i)
    else $error("R3 request without global enable");

  p_grant_requesting_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_w & ~req_v) == '0)
    else $error("R3 grant to a non-requesting source");

  p_grant_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_w))
    else $error("R9 more than one grant");

  p_cause_word_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req_o |-> (cause_o[31] && cause_o[30:12] == '0 && cause_o[11:0] == irq_id_o))
    else $error("R10 cause word malformed");

  p_vec_slot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req_o && irq_vec_o) |-> (handler_addr_o[AL-1:0] == AL'({irq_id_o, 2'b00})))
    else $error("R11 vector slot mismatch");

  p_common_align_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req_o && !irq_vec_o) |-> (handler_addr_o[5:0] == 6'd0))
    else $error("R12 common entry misaligned");

endmodule

bind vclic vclic_checker #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .mie_i          (mie_i),
  .irq_req_o      (irq_req_o),
  .irq_id_o       (irq_id_o),
  .irq_vec_o      (irq_vec_o),
  .cause_o        (cause_o),
  .handler_addr_o (handler_addr_o),
  .grant_w        (grant_w),
  .req_v          (req_v)
);

// File: tb/vclic_tb.sv
module vclic_tb_top;

  localparam int NS = 86;
  localparam int AW = $clog2(NS * 4);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] irq = '0;
  logic          mie = 1'b1;
  logic          wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    wdata = '0;
  logic [7:0]    rdata;
  logic          ack = 1'b0;
  logic [11:0]   ack_id = '0;
  logic [31:0]   tbl_base = 32'h8000_1234;
  logic [31:0]   trap_entry = 32'h2000_00FF;
  logic          req, vec;
  logic [11:0]   id;
  logic [31:0]   cause, haddr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // model of written configuration
  bit       m_en   [NS];
  bit [2:0] m_attr [NS];
  bit [7:0] m_ctl  [NS];

  always #2 clk = ~clk;

  vclic #(.NUM_SRC(NS)) dut_i (
    .clk(clk), .rst_n(rst_n), .irq_i(irq), .mie_i(mie),
    .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .ack_i(ack), .ack_id_i(ack_id), .tbl_base_i(tbl_base), .trap_entry_i(trap_entry),
    .irq_req_o(req), .irq_id_o(id), .irq_vec_o(vec), .cause_o(cause),
    .handler_addr_o(haddr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input int src, input int fld, input logic [7:0] d);
    @(negedge clk);
    wr = 1'b1; addr = AW'(src * 4 + fld); wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_rd(input int src, input int fld, output logic [7:0] d);
    @(negedge clk);
    addr = AW'(src * 4 + fld);
    #1 d = rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic do_ack(input int src);
    @(negedge clk);
    ack = 1'b1; ack_id = 12'(src);
    @(negedge clk);
    ack = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  function automatic logic [31:0] exp_vec_addr(input logic [31:0] b, input int i);
    return (b & ~32'h0000_01FF) | (32'(i) << 2);
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd24681357));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 req", 32'(req), 0);
    bus_rd(0, 3, d);  chk("R1 ctl0", 32'(d), 0);
    bus_rd(85, 1, d); chk("R1 en85", 32'(d), 0);
    bus_rd(40, 2, d); chk("R1 attr40", 32'(d), 0);
    bus_rd(7, 0, d);  chk("R1 pend7", 32'(d), 0);

    // R2 register map and widths
    bus_wr(5, 3, 8'hA5); bus_rd(5, 3, d); chk("R2 ctl", 32'(d), 32'hA5);
    bus_wr(5, 2, 8'hFF); bus_rd(5, 2, d); chk("R2 attr", 32'(d), 32'h07);
    bus_wr(5, 1, 8'hFF); bus_rd(5, 1, d); chk("R2 en", 32'(d), 32'h01);
    bus_wr(5, 2, 8'h00); bus_wr(5, 1, 8'h00);
    bus_wr(86, 3, 8'hFF); bus_rd(86, 3, d); chk("R2 out of range", 32'(d), 0);

    // R3 pending and enable and global gate
    irq[3] = 1'b1;
    bus_wr(3, 3, 8'h10);
    settle();
    chk("R3 disabled src", 32'(req), 0);
    bus_wr(3, 1, 8'h01);
    mie = 1'b0;
    settle();
    chk("R3 mie low", 32'(req), 0);
    mie = 1'b1;
    @(negedge clk);
    chk("R3 req", 32'(req), 1);
    chk("R3 id", 32'(id), 3);

    // R4 level latency: three rising edges after the change
    irq[3] = 1'b0;
    repeat (2) @(negedge clk);
    chk("R4 still high after two edges", 32'(req), 1);
    @(negedge clk);
    chk("R4 low after third edge", 32'(req), 0);
    irq[3] = 1'b1;
    settle();
    chk("R4 follows high", 32'(req), 1);

    // R7 acknowledge leaves a level source alone
    do_ack(3);
    chk("R7 level unaffected", 32'(req), 1);
    bus_wr(3, 1, 8'h00);

    // R5 rising edge
    bus_wr(10, 2, 8'h04); bus_wr(10, 3, 8'h20); bus_wr(10, 1, 8'h01);
    settle();
    chk("R5 no edge", 32'(req), 0);
    @(negedge clk) irq[10] = 1'b1;
    @(negedge clk) irq[10] = 1'b0;
    settle();
    chk("R5 held req", 32'(req), 1);
    chk("R5 id", 32'(id), 10);
    do_ack(10);
    chk("R7 edge cleared by ack", 32'(req), 0);

    // R6 falling edge
    bus_wr(11, 2, 8'h06); bus_wr(11, 3, 8'h20); bus_wr(11, 1, 8'h01);
    irq[11] = 1'b1;
    settle();
    chk("R6 rise ignored", 32'(req), 0);
    irq[11] = 1'b0;
    settle();
    chk("R6 fall req", 32'(req), 1);
    chk("R6 id", 32'(id), 11);
    do_ack(11);
    chk("R6 ack clears", 32'(req), 0);

    // R8 software pending writes
    bus_wr(10, 0, 8'h01);
    chk("R8 edge set", 32'(req), 1);
    chk("R8 edge set id", 32'(id), 10);
    bus_rd(10, 0, d); chk("R8 pend read", 32'(d), 1);
    bus_wr(10, 0, 8'h00);
    chk("R8 edge clear", 32'(req), 0);
    irq[3] = 1'b0;
    settle();
    bus_wr(3, 1, 8'h01);
    bus_wr(3, 0, 8'h01);
    bus_rd(3, 0, d); chk("R8 level write ignored", 32'(d), 0);
    chk("R8 level no req", 32'(req), 0);
    bus_wr(3, 1, 8'h00);

    // R9 ties and priority, R12 common entry
    bus_wr(20, 3, 8'h40); bus_wr(21, 3, 8'h40);
    bus_wr(20, 1, 8'h01); bus_wr(21, 1, 8'h01);
    irq[20] = 1'b1; irq[21] = 1'b1;
    settle();
    chk("R9 tie higher id", 32'(id), 21);
    chk("R12 common", haddr, 32'h2000_00C0);
    chk("R12 vec flag", 32'(vec), 0);
    bus_wr(20, 3, 8'h41);
    chk("R9 larger ctl", 32'(id), 20);

    // R11 vectored highest ID
    bus_wr(85, 2, 8'h01); bus_wr(85, 3, 8'hFF); bus_wr(85, 1, 8'h01);
    irq[85] = 1'b1;
    settle();
    chk("R11 id", 32'(id), 85);
    chk("R11 vec flag", 32'(vec), 1);
    chk("R11 addr", haddr, exp_vec_addr(tbl_base, 85));
    chk("R10 cause", cause, 32'h8000_0055);

    // Randomized level-mode scenarios: R9 R10 R11 R12
    irq = '0;
    do_reset();
    for (int r = 0; r < 24; r++) begin
      int best;
      bit [7:0] bctl;
      tbl_base   = $urandom;
      trap_entry = $urandom;
      for (int s = 0; s < NS; s++) begin
        irq[s]    = 1'($urandom % 2);
        m_en[s]   = ($urandom % 3) != 0;
        m_ctl[s]  = 8'($urandom % 4);
        m_attr[s] = {1'b0, 1'($urandom % 2), 1'($urandom % 2)};
        bus_wr(s, 1, {7'd0, m_en[s]});
        bus_wr(s, 3, m_ctl[s]);
        bus_wr(s, 2, {5'd0, m_attr[s]});
      end
      settle();
      best = -1; bctl = 0;
      for (int s = 0; s < NS; s++)
        if (irq[s] && m_en[s] && (best < 0 || m_ctl[s] >= bctl)) begin
          best = s; bctl = m_ctl[s];
        end
      chk("R9 rand req", 32'(req), (best >= 0) ? 1 : 0);
      if (best >= 0) begin
        chk("R9 rand id", 32'(id), 32'(best));
        chk("R10 rand cause", cause, 32'h8000_0000 | 32'(best));
        chk("R11 rand vec", 32'(vec), 32'(m_attr[best][0]));
        if (m_attr[best][0])
          chk("R11 rand addr", haddr, exp_vec_addr(tbl_base, best));
        else
          chk("R12 rand addr", haddr, trap_entry & ~32'h3F);
      end
    end

    finish_run();
  end

endmodule